// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit performs the state changes a processor core makes when it takes an exception or an interrupt. The core presents a trap request for one clock cycle. The request carries the cause number, a flag that marks it as an interrupt, the faulting address and the PC of the trapping instruction. The core also supplies its current privilege, its status word, its two delegation masks and its two trap-vector registers. From these the unit decides whether supervisor or machine level handles the trap. It then writes that level's cause, exception-PC and trap-value registers, rewrites the status word, computes the handler address and switches privilege.

An environment-call exception arrives under a single cause number. The unit renumbers it to the variant that matches the privilege it came from, and does so before routing. A delegation mask can therefore send user calls to supervisor and keep supervisor calls in machine. Interrupts may use vectored entry, in which each cause gets its own slot in the handler table. Exceptions always land at the vector base.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, privOut reads 3 (machine) and every other output reads zero.
- R2: A trap is routed to supervisor (privOut becomes 1) only when all three of these hold: privIn is 0 or 1, the effective cause is below 32, and bit [cause] of the mask is set. The mask is irqDeleg for interrupts and excDeleg for exceptions. Every other trap goes to machine (privOut becomes 3).
- R3: On supervisor entry, statusOut equals statusIn with three changes: bit 5 takes the old bit 1, bit 8 takes privIn[0], and bit 1 is cleared. No other bit changes.
- R4: On machine entry, statusOut equals statusIn with three changes: bit 7 takes the old bit 3, bits 12:11 take privIn, and bit 3 is cleared. No other bit changes.
- R5: The cause register of the target level receives the effective cause zero-extended, with bit 31 set for an interrupt and clear for an exception.
- R6: The exception-PC register of the target level receives curPc. The cause, exception-PC and trap-value registers of the other level keep their values.
- R7: pcOut is the target level's vector register with bits 1:0 cleared. When the trap is an interrupt and the vector's bits 1:0 equal 1, four times the cause is added.
- R8: The trap-value register of the target level receives faultAddr for exceptions with cause 0, 1, 4, 5, 6, 7, 12, 13 or 15. It receives zero for every other exception and for every interrupt.
- R9: An exception with cause 8 (environment call) takes the effective cause 8 + privIn. That value is used for routing and is the value written. Interrupt cause 8 is not renumbered.
- R10: Outputs change only on the clock edge where trapValid is high; the new privilege is visible from the cycle after the request. With trapValid low, every output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapValid | input | 1 | Trap request, one cycle per trap |
| trapIsIrq | input | 1 | 1 = interrupt, 0 = exception |
| trapCause | input | 6 | Raw cause number |
| faultAddr | input | 32 | Faulting address of the trap |
| curPc | input | 32 | PC of the trapping instruction |
| privIn | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| statusIn | input | 32 | Current status word |
| irqDeleg | input | 32 | Interrupt delegation mask |
| excDeleg | input | 32 | Exception delegation mask |
| supVec | input | 32 | Supervisor trap vector (bits 1:0 = mode) |
| machVec | input | 32 | Machine trap vector (bits 1:0 = mode) |
| privOut | output | 2 | Privilege after the last trap |
| statusOut | output | 32 | Status word after the last trap |
| pcOut | output | 32 | Handler address of the last trap |
| scause | output | 32 | Supervisor cause register |
| sepc | output | 32 | Supervisor exception PC |
| stval | output | 32 | Supervisor trap value |
| mcause | output | 32 | Machine cause register |
| mepc | output | 32 | Machine exception PC |
| mtval | output | 32 | Machine trap value |

## Verification
Two cases are hard to produce by chance: a renumbered environment call that a delegation mask splits by origin, and an interrupt with a cause of 32 or above under an all-ones mask. Random stimulus rarely builds either. Directed cases therefore give each of them the mask and privilege it needs. Constrained random traps then mix privileges, vector modes and masks, and each result is compared against a bench model of the routing rules.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN    = 32;
  localparam int CAUSE_W = 6;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int BIT_SIE  = 1;
  localparam int BIT_MIE  = 3;
  localparam int BIT_SPIE = 5;
  localparam int BIT_MPIE = 7;
  localparam int BIT_SPP  = 8;
  localparam int BIT_MPP  = 11;

  localparam logic [CAUSE_W-1:0] CAUSE_ECALL = CAUSE_W'(8);

  typedef struct packed {
    logic               wrSup;
    logic               wrMach;
    logic               isIrq;
    logic               keepAddr;
    logic               addOffset;
    logic [CAUSE_W-1:0] effCause;
  } trapStrobes_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic               trapValid,
  input  logic               trapIsIrq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [1:0]         privIn,
  input  logic [XLEN-1:0]    irqDeleg,
  input  logic [XLEN-1:0]    excDeleg,
  input  logic [1:0]         supMode,
  input  logic [1:0]         machMode,
  output trapStrobes_t       strobes
);
  localparam int IDX_W = $clog2(XLEN);

  logic [CAUSE_W-1:0] effCause;
  logic [XLEN-1:0]    delegMask;
  logic               inRange;
  logic               delegHit;
  logic               toSup;
  logic               addrCause;
  logic [1:0]         tgtMode;

  always_comb begin
    effCause = trapCause;
    if (!trapIsIrq && trapCause == CAUSE_ECALL)
      effCause = CAUSE_ECALL + CAUSE_W'(privIn);
  end

  assign delegMask = trapIsIrq ? irqDeleg : excDeleg;
  assign inRange   = (int'(effCause) < XLEN);
  assign delegHit  = delegMask[effCause[IDX_W-1:0]];
  assign toSup     = (privIn <= PRIV_S) && inRange && delegHit;

  always_comb begin
    case (effCause)
      6'd0, 6'd1, 6'd4, 6'd5, 6'd6, 6'd7, 6'd12, 6'd13, 6'd15: addrCause = 1'b1;
      default:                                                addrCause = 1'b0;
    endcase
  end

  assign tgtMode = toSup ? supMode : machMode;

  always_comb begin
    strobes.wrSup     = trapValid && toSup;
    strobes.wrMach    = trapValid && !toSup;
    strobes.isIrq     = trapIsIrq;
    strobes.keepAddr  = !trapIsIrq && addrCause;
    strobes.addOffset = trapIsIrq && (tgtMode == 2'd1);
    strobes.effCause  = effCause;
  end
endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  trapStrobes_t    strobes,
  input  logic [XLEN-1:0] faultAddr,
  input  logic [XLEN-1:0] curPc,
  input  logic [1:0]      privIn,
  input  logic [XLEN-1:0] statusIn,
  input  logic [XLEN-1:0] supVec,
  input  logic [XLEN-1:0] machVec,
  output logic [1:0]      privOut,
  output logic [XLEN-1:0] statusOut,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] scause,
  output logic [XLEN-1:0] sepc,
  output logic [XLEN-1:0] stval,
  output logic [XLEN-1:0] mcause,
  output logic [XLEN-1:0] mepc,
  output logic [XLEN-1:0] mtval
);
  localparam int PAD_W = XLEN - CAUSE_W - 1;
  localparam int OFF_W = XLEN - CAUSE_W - 2;

  logic [XLEN-1:0] newStatus;
  logic [XLEN-1:0] causeWord;
  logic [XLEN-1:0] valueWord;
  logic [XLEN-1:0] vecBase;
  logic [XLEN-1:0] vecOffset;
  logic            doTrap;

  assign doTrap = strobes.wrSup || strobes.wrMach;

  always_comb begin
    newStatus = statusIn;
    if (strobes.wrSup) begin
      newStatus[BIT_SPIE] = statusIn[BIT_SIE];
      newStatus[BIT_SPP]  = privIn[0];
      newStatus[BIT_SIE]  = 1'b0;
    end else begin
      newStatus[BIT_MPIE]          = statusIn[BIT_MIE];
      newStatus[BIT_MPP +: 2]      = privIn;
      newStatus[BIT_MIE]           = 1'b0;
    end
  end

  assign causeWord = {strobes.isIrq, {PAD_W{1'b0}}, strobes.effCause};
  assign valueWord = strobes.keepAddr ? faultAddr : '0;
  assign vecBase   = (strobes.wrSup ? supVec : machVec) & ~XLEN'(3);
  assign vecOffset = strobes.addOffset ? {{OFF_W{1'b0}}, strobes.effCause, 2'b00} : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      privOut   <= PRIV_M;
      statusOut <= '0;
      pcOut     <= '0;
      scause    <= '0;
      sepc      <= '0;
      stval     <= '0;
      mcause    <= '0;
      mepc      <= '0;
      mtval     <= '0;
    end else if (doTrap) begin
      privOut   <= strobes.wrSup ? PRIV_S : PRIV_M;
      statusOut <= newStatus;
      pcOut     <= vecBase + vecOffset;
      if (strobes.wrSup) begin
        scause <= causeWord;
        sepc   <= curPc;
        stval  <= valueWord;
      end else begin
        mcause <= causeWord;
        mepc   <= curPc;
        mtval  <= valueWord;
      end
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapValid,
  input  logic               trapIsIrq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [XLEN-1:0]    faultAddr,
  input  logic [XLEN-1:0]    curPc,
  input  logic [1:0]         privIn,
  input  logic [XLEN-1:0]    statusIn,
  input  logic [XLEN-1:0]    irqDeleg,
  input  logic [XLEN-1:0]    excDeleg,
  input  logic [XLEN-1:0]    supVec,
  input  logic [XLEN-1:0]    machVec,
  output logic [1:0]         privOut,
  output logic [XLEN-1:0]    statusOut,
  output logic [XLEN-1:0]    pcOut,
  output logic [XLEN-1:0]    scause,
  output logic [XLEN-1:0]    sepc,
  output logic [XLEN-1:0]    stval,
  output logic [XLEN-1:0]    mcause,
  output logic [XLEN-1:0]    mepc,
  output logic [XLEN-1:0]    mtval
);
  trapStrobes_t strobes;

  trap_ctrl ctrl_i (
    .trapValid (trapValid),
    .trapIsIrq (trapIsIrq),
    .trapCause (trapCause),
    .privIn    (privIn),
    .irqDeleg  (irqDeleg),
    .excDeleg  (excDeleg),
    .supMode   (supVec[1:0]),
    .machMode  (machVec[1:0]),
    .strobes   (strobes)
  );

  trap_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .faultAddr (faultAddr),
    .curPc     (curPc),
    .privIn    (privIn),
    .statusIn  (statusIn),
    .supVec    (supVec),
    .machVec   (machVec),
    .privOut   (privOut),
    .statusOut (statusOut),
    .pcOut     (pcOut),
    .scause    (scause),
    .sepc      (sepc),
    .stval     (stval),
    .mcause    (mcause),
    .mepc      (mepc),
    .mtval     (mtval)
  );
endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker
  import trap_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               trapValid,
  input logic               trapIsIrq,
  input logic [XLEN-1:0]    curPc,
  input logic [1:0]         privIn,
  input logic [XLEN-1:0]    statusIn,
  input logic [1:0]         privOut,
  input logic [XLEN-1:0]    statusOut,
  input logic [XLEN-1:0]    pcOut,
  input logic [XLEN-1:0]    scause,
  input logic [XLEN-1:0]    sepc,
  input logic [XLEN-1:0]    mcause,
  input logic [XLEN-1:0]    mepc
);
  p_machine_stays_r2: assert property (@(posedge clk) disable iff (!rstN)
    trapValid && privIn == PRIV_M |=> privOut == PRIV_M);

  p_target_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (privOut == PRIV_S || privOut == PRIV_M));

  p_enable_cleared_r3: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (privOut == PRIV_M ? !statusOut[BIT_MIE] : !statusOut[BIT_SIE]));

  p_prev_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    trapValid && privIn == PRIV_M |=> statusOut[BIT_MPIE] == $past(statusIn[BIT_MIE]));

  p_cause_msb_r5: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (privOut == PRIV_M ? mcause[XLEN-1] : scause[XLEN-1]) == $past(trapIsIrq));

  p_epc_r6: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (privOut == PRIV_M ? mepc : sepc) == $past(curPc));

  p_pc_aligned_r7: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> pcOut[1:0] == 2'b00);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |=> $stable(privOut) && $stable(statusOut) && $stable(pcOut)
                   && $stable(mepc) && $stable(sepc));
endmodule

bind trap_entry_unit trap_entry_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .trapValid (trapValid),
  .trapIsIrq (trapIsIrq),
  .curPc     (curPc),
  .privIn    (privIn),
  .statusIn  (statusIn),
  .privOut   (privOut),
  .statusOut (statusOut),
  .pcOut     (pcOut),
  .scause    (scause),
  .sepc      (sepc),
  .mcause    (mcause),
  .mepc      (mepc)
);

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapValid = 1'b0, trapIsIrq = 1'b0;
  logic [5:0]  trapCause = '0;
  logic [31:0] faultAddr = '0, curPc = '0, statusIn = '0;
  logic [1:0]  privIn = '0;
  logic [31:0] irqDeleg = '0, excDeleg = '0, supVec = '0, machVec = '0;
  logic [1:0]  privOut;
  logic [31:0] statusOut, pcOut, scause, sepc, stval, mcause, mepc, mtval;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 0;

  logic [1:0]  ePriv;
  logic [31:0] eStatus, ePc, eScause, eSepc, eStval, eMcause, eMepc, eMtval;

  always #10 clk = ~clk;

  trap_entry_unit dut_i (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .trapIsIrq(trapIsIrq),
    .trapCause(trapCause), .faultAddr(faultAddr), .curPc(curPc), .privIn(privIn),
    .statusIn(statusIn), .irqDeleg(irqDeleg), .excDeleg(excDeleg),
    .supVec(supVec), .machVec(machVec), .privOut(privOut), .statusOut(statusOut),
    .pcOut(pcOut), .scause(scause), .sepc(sepc), .stval(stval),
    .mcause(mcause), .mepc(mepc), .mtval(mtval));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " R2 privOut"}, {30'd0, privOut}, {30'd0, ePriv});
    check({tag, " R3/R4 statusOut"}, statusOut, eStatus);
    check({tag, " R7 pcOut"}, pcOut, ePc);
    check({tag, " R5/R9 scause"}, scause, eScause);
    check({tag, " R6 sepc"}, sepc, eSepc);
    check({tag, " R8 stval"}, stval, eStval);
    check({tag, " R5/R9 mcause"}, mcause, eMcause);
    check({tag, " R6 mepc"}, mepc, eMepc);
    check({tag, " R8 mtval"}, mtval, eMtval);
  endtask

  // Bench model of the requirements
  task automatic modelTrap();
    logic [5:0]  c;
    logic [31:0] mask, vec, s, cw, tv;
    logic        sup;
    c = trapCause;
    if (!trapIsIrq && c == 6'd8) c = 6'd8 + {4'd0, privIn};       // R9
    mask = trapIsIrq ? irqDeleg : excDeleg;
    sup = (privIn <= 2'd1) && (c < 6'd32) && mask[c[4:0]];         // R2
    s = statusIn;
    if (sup) begin s[5] = s[1]; s[8] = privIn[0]; s[1] = 1'b0; end // R3
    else begin s[7] = s[3]; s[12:11] = privIn; s[3] = 1'b0; end    // R4
    cw = {trapIsIrq, 25'd0, c};                                    // R5
    tv = (!trapIsIrq && (c inside {0,1,4,5,6,7,12,13,15})) ? faultAddr : 32'd0; // R8
    vec = sup ? supVec : machVec;
    ePc = {vec[31:2], 2'b00} + ((trapIsIrq && vec[1:0] == 2'd1) ? {24'd0, c, 2'b00} : 32'd0); // R7
    ePriv = sup ? 2'd1 : 2'd3;
    eStatus = s;
    if (sup) begin eScause = cw; eSepc = curPc; eStval = tv; end   // R6
    else begin eMcause = cw; eMepc = curPc; eMtval = tv; end
  endtask

  task automatic doTrap(input string tag, input logic irq, input logic [5:0] cause,
                        input logic [1:0] pr, input logic [31:0] ided, input logic [31:0] eded);
    @(negedge clk);
    trapIsIrq = irq; trapCause = cause; privIn = pr;
    irqDeleg = ided; excDeleg = eded;
    faultAddr = $urandom; curPc = $urandom; statusIn = $urandom;
    trapValid = 1'b1;
    modelTrap();
    @(negedge clk);
    trapValid = 1'b0;
    checkAll(tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    ePriv = 2'd3; eStatus = 0; ePc = 0; eScause = 0; eSepc = 0; eStval = 0;
    eMcause = 0; eMepc = 0; eMtval = 0;
    @(negedge clk);
    checkAll("R1 reset");

    supVec = 32'h0000_4001; machVec = 32'h0000_8001;
    // R2: cause >= 32 never delegated even with full mask
    doTrap("R2 wide cause", 1'b1, 6'd40, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R2: machine privilege ignores delegation
    doTrap("R2 from M", 1'b0, 6'd13, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R9: ecall from U delegated, ecall from S not
    doTrap("R9 ecall U", 1'b0, 6'd8, 2'd0, 32'h0, 32'h0000_0100);
    doTrap("R9 ecall S", 1'b0, 6'd8, 2'd1, 32'h0, 32'h0000_0100);
    // R9: interrupt cause 8 not renumbered
    doTrap("R9 irq 8", 1'b1, 6'd8, 2'd1, 32'h0000_0100, 32'h0);
    // R7: vectored interrupt to S; exception with vectored mode has no offset
    doTrap("R7 vec irq", 1'b1, 6'd5, 2'd0, 32'h0000_0020, 32'h0);
    doTrap("R7 vec exc", 1'b0, 6'd2, 2'd0, 32'h0, 32'h0000_0004);
    // R8: interrupt with address-type number gives zero value
    doTrap("R8 irq tval", 1'b1, 6'd13, 2'd3, 32'h0, 32'h0);
    // R10: hold with trapValid low while inputs change
    @(negedge clk);
    trapIsIrq = 1'b1; trapCause = 6'd3; curPc = 32'hDEAD_BEEF; statusIn = '1;
    repeat (3) @(negedge clk);
    checkAll("R10 hold");

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [5:0] cz;
      logic [31:0] dm;
      supVec  = $urandom;
      machVec = $urandom;
      case ($urandom % 4)
        0: cz = 6'd8;
        1: cz = 6'(32 + $urandom % 32);
        default: cz = 6'($urandom % 16);
      endcase
      dm = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      doTrap("rand", 1'($urandom), cz, 2'($urandom), dm, $urandom);
      if ($urandom % 3 == 0) begin
        curPc = $urandom; statusIn = $urandom;
        @(negedge clk);
        checkAll("R10 rand idle");
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule